// File: doc/BRIEF.md
# Signed Non-Restoring Fraction Divider

This block divides a double-length two's-complement dividend by a single-length divisor, all words 24 bits wide with bit 23 as the sign. The dividend is presented as a high word and a low word. The block runs a non-restoring algorithm that makes one partial-remainder step per clock. It returns a quotient, the final partial remainder, an overflow flag and a flag for one special operand pattern.

A caller holds the operands on the inputs and raises `start` for one cycle while the block is idle. With a non-zero divisor, the block makes 24 steps and then raises `done` for one cycle. A zero divisor ends the operation at once. The result outputs keep their values until the next operation completes.

Top module: `frac_divider`

## Requirements
- R1: After reset, `done`, `ovf` and `special` are 0, and `quotient` and `remainder` are 0.
- R2: If `start` is accepted with `dvsr` equal to 0, then on the next clock `done` is 1, `ovf` is 1, and `quotient` and `remainder` are 0.
- R3: When `done` is raised, `special` is 1 exactly when the accepted operands were `dvsr` = 0xFFFFFF, `dvd_lo` = 0x000001 and `dvd_hi` = 0.
- R4: Each step either subtracts the divisor from the partial remainder (adds its ones' complement plus one) or adds the divisor, modulo 2^24. The first step subtracts when bit 23 of `dvd_hi` equals bit 23 of the divisor. Every later step subtracts exactly when the previous step produced a quotient bit of 1.
- R5: A step produces a quotient bit of 1 when bit 23 of its new partial remainder equals bit 23 of the divisor. The 24 bits are collected MSB first, so the first step's bit becomes `quotient[23]`.
- R6: Between steps, the partial remainder is shifted left one place and the next bit of `dvd_lo` enters at its LSB, taken from bit 23 downward. Bit 0 of `dvd_lo` never reaches the remainder.
- R7: With a non-zero divisor, `done` is 1 for exactly one cycle, 24 clocks after the clock that accepted `start`. `remainder` is the unshifted partial remainder of the last step.
- R8: `ovf` equals the quotient bit of the first step, except that it is 0 when `dvd_hi` and `dvd_lo` are both 0.
- R9: `start` has no effect while an operation is in progress.
- R10: `quotient`, `remainder`, `ovf` and `special` change only in the cycle where `done` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a division |
| dvd_hi | input | 24 | High word of the dividend |
| dvd_lo | input | 24 | Low word of the dividend |
| dvsr | input | 24 | Divisor |
| quotient | output | 24 | Quotient bits, first step in the MSB |
| remainder | output | 24 | Final partial remainder |
| ovf | output | 1 | Overflow / carry result |
| special | output | 1 | Special operand pattern seen |
| done | output | 1 | One-cycle completion strobe |

## Verification
The assertions assume that `start` and the operand inputs are settled at each rising edge. They also assume that the operands need to be valid only in the cycle where `start` is accepted, because the block latches them. The stimulus changes inputs only on falling edges. It holds `start` for one cycle and waits for the expected completion before the next request, except in the deliberate test that pulses `start` in the middle of a run. The randomised operands cover every sign combination and both overflow and non-overflow outcomes, with no restriction on their values.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;
  typedef enum logic [1:0] {
    STEP_FIRST = 2'd0,
    STEP_MID   = 2'd1,
    STEP_LAST  = 2'd2
  } step_kind_t;
endpackage

// File: rtl/div_step.sv
module div_step #(
  parameter int W = 24
) (
  input  logic [W-1:0] rem_in,
  input  logic [W-1:0] divisor,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         qbit
);
  // subtract as complement-plus-one so one adder serves both directions
  always_comb begin
    if (sub) sum = rem_in + ~divisor + W'(1);
    else     sum = rem_in + divisor;
    qbit = (sum[W-1] == divisor[W-1]);
  end
endmodule

// File: rtl/div_ctrl.sv
module div_ctrl
  import frac_div_pkg::*;
#(
  parameter int W = 24
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  output logic       busy,
  output logic       fin,
  output step_kind_t kind
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (go) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end else if (cnt == LAST) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  always_comb begin
    fin = busy && (cnt == LAST);
    if (cnt == '0)       kind = STEP_FIRST;
    else if (cnt == LAST) kind = STEP_LAST;
    else                 kind = STEP_MID;
  end

  // R7: a run keeps going until its last step
  a_r7_run_continues: assert property (@(posedge clk) disable iff (rst)
    (busy && !fin) |=> busy);
  // R9: the step count advances by one while busy, a new start cannot reload it
  a_r9_count_advances: assert property (@(posedge clk) disable iff (rst)
    (busy && !fin) |=> (cnt == $past(cnt) + CW'(1)));
endmodule

// File: rtl/frac_divider.sv
module frac_divider
  import frac_div_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] dvd_hi,
  input  logic [W-1:0] dvd_lo,
  input  logic [W-1:0] dvsr,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         ovf,
  output logic         special,
  output logic         done
);
  logic         busy, fin;
  step_kind_t   kind;
  logic         accept, go, sub, qbit;
  logic [W-1:0] pr, lo, dv_q, sum;
  logic         qlast, carry, zdiv, spec_q;

  assign accept = start && !busy;
  assign go     = accept && (dvsr != '0);

  div_ctrl #(.W(W)) u_ctrl (
    .clk  (clk),
    .rst  (rst),
    .go   (go),
    .busy (busy),
    .fin  (fin),
    .kind (kind)
  );

  // first step compares signs of the high word and divisor, later steps follow the last quotient bit
  assign sub = (kind == STEP_FIRST) ? (pr[W-1] == dv_q[W-1]) : qlast;

  div_step #(.W(W)) u_step (
    .rem_in  (pr),
    .divisor (dv_q),
    .sub     (sub),
    .sum     (sum),
    .qbit    (qbit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pr        <= '0;
      lo        <= '0;
      dv_q      <= '0;
      qlast     <= 1'b0;
      carry     <= 1'b0;
      zdiv      <= 1'b0;
      spec_q    <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
      ovf       <= 1'b0;
      special   <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        dv_q   <= dvsr;
        pr     <= dvd_hi;
        lo     <= dvd_lo;
        zdiv   <= (dvd_hi == '0) && (dvd_lo == '0);
        spec_q <= (dvsr == '1) && (dvd_lo == W'(1)) && (dvd_hi == '0);
        if (dvsr == '0) begin
          quotient  <= '0;
          remainder <= '0;
          ovf       <= 1'b1;
          special   <= 1'b0;
          done      <= 1'b1;
        end
      end else if (busy) begin
        qlast <= qbit;
        if (kind == STEP_FIRST) carry <= qbit;
        if (fin) begin
          quotient  <= {lo[W-2:0], qbit};
          remainder <= sum;
          ovf       <= carry && !zdiv;
          special   <= spec_q;
          done      <= 1'b1;
        end else begin
          pr <= {sum[W-2:0], lo[W-1]};
          lo <= {lo[W-2:0], qbit};
        end
      end
    end
  end

  // R2: zero divisor finishes on the next clock with overflow
  a_r2_zero_divisor: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && dvsr == '0) |=> (done && ovf && quotient == '0 && remainder == '0));
  // R7: the last step is followed by the done strobe
  a_r7_done_after_final: assert property (@(posedge clk) disable iff (rst)
    fin |=> done);
  // R8: a zero dividend never reports overflow
  a_r8_zero_dividend: assert property (@(posedge clk) disable iff (rst)
    (fin && zdiv) |=> !ovf);
  // R10: results hold while a run is in progress
  a_r10_hold_results: assert property (@(posedge clk) disable iff (rst)
    (busy && !fin) |=> ($stable(quotient) && $stable(remainder) && $stable(ovf)));
endmodule

// File: tb/tb_frac_divider.sv
module tb_frac_divider;
  typedef struct packed {
    logic [23:0] q;
    logic [23:0] rm;
    logic        ov;
    logic        sp;
  } res_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [23:0] dvd_hi = '0, dvd_lo = '0, dvsr = '0;
  logic [23:0] quotient, remainder;
  logic        ovf, special, done;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit checking = 1'b0;

  always #10 clk = ~clk;

  frac_divider dut (
    .clk(clk), .rst(rst), .start(start), .dvd_hi(dvd_hi), .dvd_lo(dvd_lo),
    .dvsr(dvsr), .quotient(quotient), .remainder(remainder), .ovf(ovf),
    .special(special), .done(done)
  );

  task automatic check(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural model of the stated step rules
  function automatic res_t ref_div(input logic [23:0] hi, input logic [23:0] lo, input logic [23:0] dv);
    res_t o;
    logic [23:0] r, s, quo;
    bit subn, qb, firstq;
    o.sp = (dv == 24'hFFFFFF) && (lo == 24'd1) && (hi == 24'd0);
    if (dv == 24'd0) begin
      o.q = '0; o.rm = '0; o.ov = 1'b1; o.sp = 1'b0;
      return o;
    end
    r = hi; quo = '0; s = '0; firstq = 1'b0;
    subn = (hi[23] == dv[23]);
    for (int k = 0; k < 24; k++) begin
      s = subn ? (r - dv) : (r + dv);
      qb = (s[23] == dv[23]);
      quo = {quo[22:0], qb};
      if (k == 0) firstq = qb;
      subn = qb;
      if (k < 23) r = {s[22:0], lo[23-k]};
    end
    o.q = quo; o.rm = s;
    o.ov = firstq && !((hi == 24'd0) && (lo == 24'd0));
    return o;
  endfunction

  bit   mbusy;
  int   mleft;
  bit   exp_done;
  res_t exp_res, pend;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      mbusy <= 1'b0; mleft <= 0; exp_done <= 1'b0; exp_res <= '0; pend <= '0;
    end else begin
      exp_done <= 1'b0;
      if (mbusy) begin
        if (mleft == 1) begin
          mbusy <= 1'b0; exp_done <= 1'b1; exp_res <= pend;
        end else mleft <= mleft - 1;
      end else if (start) begin
        if (dvsr == 24'd0) begin
          exp_done <= 1'b1; exp_res <= ref_div(dvd_hi, dvd_lo, dvsr);
        end else begin
          mbusy <= 1'b1; mleft <= 24; pend <= ref_div(dvd_hi, dvd_lo, dvsr);
        end
      end
    end
  end

  // compared on every falling edge
  always @(negedge clk) begin
    if (checking && !rst) begin
      check(done === exp_done, "R7 done timing", {23'd0, done}, {23'd0, exp_done});
      check(quotient === exp_res.q, "R5 R10 quotient", quotient, exp_res.q);
      check(remainder === exp_res.rm, "R4 R6 remainder", remainder, exp_res.rm);
      check(ovf === exp_res.ov, "R8 overflow", {23'd0, ovf}, {23'd0, exp_res.ov});
      check(special === exp_res.sp, "R3 special", {23'd0, special}, {23'd0, exp_res.sp});
    end
  end

  always @(posedge clk) begin
    if (cyc == 150000) begin
      fails++;
      $display("FAIL R7 watchdog expired actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic run_op(input logic [23:0] hi, input logic [23:0] lo, input logic [23:0] dv);
    @(negedge clk);
    dvd_hi = hi; dvd_lo = lo; dvsr = dv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (dv == 24'd0) repeat (2) @(negedge clk);
    else repeat (26) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(done === 1'b0, "R1 done", {23'd0, done}, 24'd0);
    check(quotient === 24'd0, "R1 quotient", quotient, 24'd0);
    check(remainder === 24'd0, "R1 remainder", remainder, 24'd0);
    check({ovf, special} === 2'b00, "R1 flags", {22'd0, ovf, special}, 24'd0);
    checking = 1'b1;

    run_op(24'h000000, 24'h000000, 24'h000000);   // R2
    run_op(24'h000123, 24'h000456, 24'h000000);   // R2
    run_op(24'h000000, 24'h000001, 24'hFFFFFF);   // R3
    run_op(24'h000000, 24'h000002, 24'hFFFFFF);   // R3 negative case
    run_op(24'h000000, 24'h000000, 24'hFFFFFD);   // R8 zero dividend
    run_op(24'h000000, 24'h000000, 24'h000007);   // R8
    run_op(24'h000005, 24'h000000, 24'h000003);   // R8 overflow
    run_op(24'h000000, 24'h400000, 24'h000003);   // R4 R5
    run_op(24'hFFFFFF, 24'h800000, 24'h000005);   // R4 negative dividend
    run_op(24'h000001, 24'h000000, 24'h7FFFFF);
    run_op(24'hFFF000, 24'h123456, 24'hFF0001);
    run_op(24'h000000, 24'hAAAAAB, 24'h000155);   // R6 low word pattern
    run_op(24'h000000, 24'hAAAAAA, 24'h000155);   // R6 bit 0 unused

    // R9: start pulsed mid-run with other operands is ignored
    @(negedge clk);
    dvd_hi = 24'h000010; dvd_lo = 24'h345678; dvsr = 24'h000321; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    dvd_hi = 24'h000000; dvd_lo = 24'h000000; dvsr = 24'h000000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (22) @(negedge clk);

    for (int i = 0; i < 30; i++) begin
      run_op(24'($urandom), 24'($urandom), 24'($urandom));
    end
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule